// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of one line in a write-back cache that sits on a shared snooping bus. The line is in one of four states: Invalid, Shared, Exclusive or Modified. The block sees two kinds of traffic. The first is read and write requests from its own processor. The second is read and read-for-ownership transactions from other caches on the bus. It reports whether a processor access hits the line's tag and whether the access can complete. It raises bus requests for a fill, for an ownership claim or for the write-back of dirty data. It pulses a flush strobe whenever dirty data leaves the line, and it drives its share of a wired-OR shared signal.

A clean line held by no other cache enters Exclusive. A later write can then move it to Modified without any bus transaction, so private data needs no invalidate. Bus arbitration is outside the block: it receives a grant, and the bus transaction takes place in the cycle when its request and the grant are both high. Snooped transactions arrive on separate inputs. The surrounding bus must not present a master's own transaction to that master as a snoop.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (`lineState` = 0; the encoding is 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified), and `busReq`, `cpuDone`, `flushStb` and `sharedOut` are low.
- R2: A processor read that misses requests the bus with `busCmd` = 1 (read) and `busTag` equal to `cpuTag`. At the end of the granted cycle the line takes the new tag. It enters Shared if `busShared` was high in that cycle and Exclusive if it was low.
- R3: A processor write to an Exclusive line that hits the tag completes in the same cycle with no bus request. From the next cycle the line is Modified.
- R4: A processor write to a Shared line that hits the tag, or to an Invalid line, requests the bus with `busCmd` = 2 (read for ownership). After the granted cycle the line is Modified.
- R5: A read that hits the tag in Shared, Exclusive or Modified completes in the same cycle (`cpuDone` = 1, `cpuHit` = 1) with no bus request. So does a write that hits the tag in Modified.
- R6: A snooped read (`snpCmd` = 0) that matches the tag of a valid line raises `sharedOut` in that cycle. If the line is Modified, it also raises `flushStb`. The line is Shared afterwards.
- R7: A snooped read for ownership (`snpCmd` = 1) that matches the tag of a valid line makes it Invalid. It raises `flushStb` only if the line was Modified, and it never raises `sharedOut`.
- R8: A miss while the line is Modified under another tag first requests a write-back: `busCmd` = 3, `busTag` = old tag, and `flushStb` high in the granted cycle. The line is then Invalid, and the request for the new tag follows.
- R9: A snoop that acts on the line takes priority in its cycle. In that cycle no processor access completes and no own bus transaction occurs, even with the grant high. The processor request is decided again in the next cycle against the updated state.
- R10: A snoop on an Invalid line, or one whose tag does not match, changes nothing and raises neither `sharedOut` nor `flushStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access pending, held until `cpuDone` |
| cpuWr | input | 1 | Access is a write |
| cpuTag | input | TAG_W | Tag of the processor access |
| cpuDone | output | 1 | Access completes this cycle |
| cpuHit | output | 1 | Access tag matches a valid line |
| busReq | output | 1 | Bus transaction wanted |
| busGrant | input | 1 | Bus granted to this controller this cycle |
| busValid | output | 1 | Own transaction on the bus this cycle |
| busCmd | output | 2 | 1 read, 2 read for ownership, 3 write-back |
| busTag | output | TAG_W | Tag of the own transaction |
| busShared | input | 1 | Wired-OR shared line seen by the requester |
| flushStb | output | 1 | Dirty data leaves the line this cycle |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 1 | 0 read, 1 read for ownership |
| snpTag | input | TAG_W | Tag of the snooped transaction |
| sharedOut | output | 1 | This cache's drive of the shared line |
| lineState | output | 2 | Current coherence state |

## Verification
Two things can fall in the same cycle: a snoop that acts on the line, and a processor access or an own bus grant. The bench provokes this in two ways. It presents a write hit on an Exclusive line together with a snooped read. It also holds the grant high while a snooped read for ownership arrives. The bench confirms that the snoop alone acts, that nothing completes or goes on the bus in that cycle, and that in the next cycle the held request is decided again against the new state, with the expected command.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  localparam logic SNP_RD  = 1'b0;
  localparam logic SNP_RDX = 1'b1;

  // strobes from control to the tag datapath
  typedef struct packed {
    logic loadTag;   // capture cpuTag at the end of the cycle
    logic selOld;    // bus carries the held tag instead of cpuTag
  } dpStrobe_t;

endpackage

// File: rtl/mesi_line_dp.sv
module mesi_line_dp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [TAG_W-1:0] cpuTag,
  input  logic [TAG_W-1:0] snpTag,
  output logic             cpuMatch,
  output logic             snpMatch,
  output logic [TAG_W-1:0] busTag
);

  logic [TAG_W-1:0] tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) tagQ <= '0;
    else if (strobe.loadTag) tagQ <= cpuTag;
  end

  always_comb begin
    cpuMatch = (tagQ == cpuTag);
    snpMatch = (tagQ == snpTag);
    busTag   = strobe.selOld ? tagQ : cpuTag;
  end

endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
  import mesi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWr,
  input  logic       cpuMatch,
  input  logic       snpValid,
  input  logic       snpCmd,
  input  logic       snpMatch,
  input  logic       busGrant,
  input  logic       busShared,
  output lineState_t stateQ,
  output dpStrobe_t  strobe,
  output logic       cpuDone,
  output logic       cpuHit,
  output logic       busReq,
  output logic       busValid,
  output busCmd_t    busCmd,
  output logic       flushStb,
  output logic       sharedOut
);

  lineState_t stateD;
  logic lineValid, snpAct, rdOk, wrOk;

  // decision logic
  always_comb begin
    lineValid = (stateQ != LS_INV);
    snpAct    = snpValid && snpMatch && lineValid;
    cpuHit    = cpuReq && cpuMatch && lineValid;
    rdOk      = cpuHit && !cpuWr;
    wrOk      = cpuHit && cpuWr && (stateQ == LS_MOD || stateQ == LS_EXC);
    cpuDone   = (rdOk || wrOk) && !snpAct;

    busCmd = BC_NONE;
    if (cpuReq && !(rdOk || wrOk)) begin
      if (stateQ == LS_MOD && !cpuMatch)      busCmd = BC_WB;
      else if (!cpuMatch || !lineValid)       busCmd = cpuWr ? BC_RDX : BC_RD;
      else                                    busCmd = BC_RDX;   // write upgrade from Shared
    end
    busReq   = (busCmd != BC_NONE);
    busValid = busReq && busGrant && !snpAct;

    sharedOut = snpAct && (snpCmd == SNP_RD);
    flushStb  = (snpAct && stateQ == LS_MOD) || (busValid && busCmd == BC_WB);

    strobe.selOld  = (busCmd == BC_WB);
    strobe.loadTag = busValid && (busCmd == BC_RD || busCmd == BC_RDX);
  end

  // next state: snoop first, then own bus transaction, then silent upgrade
  always_comb begin
    stateD = stateQ;
    if (snpAct) begin
      stateD = (snpCmd == SNP_RD) ? LS_SHR : LS_INV;
    end else if (busValid) begin
      unique case (busCmd)
        BC_WB:   stateD = LS_INV;
        BC_RD:   stateD = busShared ? LS_SHR : LS_EXC;
        BC_RDX:  stateD = LS_MOD;
        default: stateD = stateQ;
      endcase
    end else if (wrOk && stateQ == LS_EXC) begin
      stateD = LS_MOD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= LS_INV;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWr,
  input  logic [TAG_W-1:0] cpuTag,
  output logic             cpuDone,
  output logic             cpuHit,
  output logic             busReq,
  input  logic             busGrant,
  output logic             busValid,
  output logic [1:0]       busCmd,
  output logic [TAG_W-1:0] busTag,
  input  logic             busShared,
  output logic             flushStb,
  input  logic             snpValid,
  input  logic             snpCmd,
  input  logic [TAG_W-1:0] snpTag,
  output logic             sharedOut,
  output logic [1:0]       lineState
);

  dpStrobe_t  strobe;
  lineState_t stateQ;
  busCmd_t    cmdE;
  logic       cpuMatch, snpMatch;

  mesi_line_dp #(.TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuTag(cpuTag), .snpTag(snpTag),
    .cpuMatch(cpuMatch), .snpMatch(snpMatch), .busTag(busTag)
  );

  mesi_line_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuMatch(cpuMatch),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpMatch(snpMatch),
    .busGrant(busGrant), .busShared(busShared),
    .stateQ(stateQ), .strobe(strobe),
    .cpuDone(cpuDone), .cpuHit(cpuHit),
    .busReq(busReq), .busValid(busValid), .busCmd(cmdE),
    .flushStb(flushStb), .sharedOut(sharedOut)
  );

  assign busCmd    = cmdE;
  assign lineState = stateQ;

endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuDone,
  input logic       cpuWr,
  input logic       busReq,
  input logic       busValid,
  input logic [1:0] busCmd,
  input logic       busShared,
  input logic       flushStb,
  input logic       sharedOut,
  input logic       snpValid,
  input logic       snpCmd,
  input logic [1:0] lineState
);

  a_r2_fill_state: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd1 |=> lineState == ($past(busShared) ? 2'd1 : 2'd2));

  a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone && cpuWr && lineState == 2'd2 |=> lineState == 2'd3);

  a_r4_own_to_mod: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd2 |=> lineState == 2'd3);

  a_r5_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !busReq && !busValid);

  a_r6_snoop_rd_shared: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |=> lineState == 2'd1);

  a_r7_share_only_rd: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> snpValid && snpCmd == 1'b0);

  a_r8_wb_flush: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd3 |-> flushStb);

  a_r8_wb_to_inv: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd3 |=> lineState == 2'd0);

  a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut || (flushStb && !busValid) |-> !cpuDone && !busValid);

endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuDone(cpuDone), .cpuWr(cpuWr),
  .busReq(busReq), .busValid(busValid), .busCmd(busCmd), .busShared(busShared),
  .flushStb(flushStb), .sharedOut(sharedOut), .snpValid(snpValid),
  .snpCmd(snpCmd), .lineState(lineState)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;

  localparam int TW = 12;
  localparam logic [TW-1:0] TA = 12'h0A1, TB = 12'h0B2, TC = 12'h0C3, TD = 12'h0D4;

  logic clk = 0, rstN = 0;
  logic cpuReq = 0, cpuWr = 0, busGrant = 0, busShared = 0;
  logic snpValid = 0, snpCmd = 0;
  logic [TW-1:0] cpuTag = '0, snpTag = '0;
  logic cpuDone, cpuHit, busReq, busValid, flushStb, sharedOut;
  logic [1:0] busCmd, lineState;
  logic [TW-1:0] busTag;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  mesi_line_ctrl #(.TAG_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuTag(cpuTag),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .busReq(busReq), .busGrant(busGrant),
    .busValid(busValid), .busCmd(busCmd), .busTag(busTag), .busShared(busShared),
    .flushStb(flushStb), .snpValid(snpValid), .snpCmd(snpCmd), .snpTag(snpTag),
    .sharedOut(sharedOut), .lineState(lineState)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance to the middle of the next cycle
  task automatic nextCyc();
    @(posedge clk);
    #5;
  endtask

  task automatic quiet();
    cpuReq = 0; cpuWr = 0; busGrant = 0; busShared = 0; snpValid = 0; snpCmd = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "lineState", lineState, 0);
    chk("R1", "busReq", busReq, 0);
    chk("R1", "cpuDone", cpuDone, 0);
    chk("R1", "flushStb", flushStb, 0);
    chk("R1", "sharedOut", sharedOut, 0);
  endtask

  task automatic t_read_miss_excl();
    cpuReq = 1; cpuWr = 0; cpuTag = TA; #1;
    chk("R2", "busReq", busReq, 1);
    chk("R2", "busCmd", busCmd, 1);
    chk("R2", "busTag", busTag, TA);
    chk("R2", "cpuDone before fill", cpuDone, 0);
    busGrant = 1; busShared = 0; #1;
    chk("R2", "busValid", busValid, 1);
    nextCyc(); busGrant = 0; #1;
    chk("R2", "state after unshared fill", lineState, 2);
    chk("R5", "read hit done", cpuDone, 1);
    chk("R5", "read hit flag", cpuHit, 1);
    chk("R5", "read hit no busReq", busReq, 0);
  endtask

  task automatic t_silent_write();
    cpuWr = 1; #1;
    chk("R3", "write on E done", cpuDone, 1);
    chk("R3", "write on E no busReq", busReq, 0);
    nextCyc();
    chk("R3", "state after E write", lineState, 3);
    chk("R5", "write hit on M done", cpuDone, 1);
    chk("R5", "write hit on M no busReq", busReq, 0);
    quiet();
  endtask

  task automatic t_snoop_rd_mod();
    snpValid = 1; snpCmd = 0; snpTag = TA; #1;
    chk("R6", "flush on M", flushStb, 1);
    chk("R6", "shared on M", sharedOut, 1);
    nextCyc(); quiet();
    chk("R6", "state after snoop read", lineState, 1);
  endtask

  task automatic t_write_shared();
    cpuReq = 1; cpuWr = 1; cpuTag = TA; #1;
    chk("R4", "upgrade busReq", busReq, 1);
    chk("R4", "upgrade busCmd", busCmd, 2);
    chk("R4", "upgrade not done", cpuDone, 0);
    chk("R4", "hit flag on S write", cpuHit, 1);
    busGrant = 1; #1;
    nextCyc(); busGrant = 0; #1;
    chk("R4", "state after upgrade", lineState, 3);
    chk("R4", "write done after upgrade", cpuDone, 1);
    quiet();
  endtask

  task automatic t_snoop_rdx_mod();
    snpValid = 1; snpCmd = 1; snpTag = TA; #1;
    chk("R7", "flush on M", flushStb, 1);
    chk("R7", "no shared", sharedOut, 0);
    nextCyc(); quiet();
    chk("R7", "state after invalidate", lineState, 0);
    snpCmd = 0; snpValid = 1; #1;
    chk("R10", "snoop on I shared", sharedOut, 0);
    chk("R10", "snoop on I flush", flushStb, 0);
    nextCyc(); quiet();
    chk("R10", "state stays I", lineState, 0);
  endtask

  task automatic t_read_miss_shared();
    cpuReq = 1; cpuWr = 0; cpuTag = TB; #1;
    busGrant = 1; busShared = 1; #1;
    nextCyc(); busGrant = 0; busShared = 0; #1;
    chk("R2", "state after shared fill", lineState, 1);
    chk("R5", "read hit in S", cpuDone, 1);
    chk("R5", "no bus on S read", busReq, 0);
    quiet();
    snpValid = 1; snpCmd = 0; snpTag = TB; #1;
    chk("R6", "shared on S", sharedOut, 1);
    chk("R6", "no flush on S", flushStb, 0);
    nextCyc(); quiet();
    chk("R6", "stays S", lineState, 1);
    snpValid = 1; snpCmd = 1; snpTag = TC; #1;
    chk("R10", "mismatch flush", flushStb, 0);
    chk("R10", "mismatch shared", sharedOut, 0);
    nextCyc(); quiet();
    chk("R10", "mismatch keeps S", lineState, 1);
  endtask

  task automatic t_writeback();
    cpuReq = 1; cpuWr = 1; cpuTag = TB; busGrant = 1; #1;
    nextCyc(); quiet();
    chk("R4", "M on tag B", lineState, 3);
    cpuReq = 1; cpuWr = 0; cpuTag = TD; #1;
    chk("R8", "wb busCmd", busCmd, 3);
    chk("R8", "wb busTag old", busTag, TB);
    chk("R8", "no flush before grant", flushStb, 0);
    busGrant = 1; #1;
    chk("R8", "flush on wb grant", flushStb, 1);
    nextCyc(); busGrant = 0; #1;
    chk("R8", "I after wb", lineState, 0);
    chk("R8", "then read cmd", busCmd, 1);
    chk("R8", "then new tag", busTag, TD);
    busGrant = 1; #1;
    nextCyc(); busGrant = 0; #1;
    chk("R2", "E on tag D", lineState, 2);
    quiet();
  endtask

  task automatic t_priority();
    cpuReq = 1; cpuWr = 1; cpuTag = TD;
    snpValid = 1; snpCmd = 0; snpTag = TD; #1;
    chk("R9", "write blocked by snoop", cpuDone, 0);
    chk("R9", "snoop acts", sharedOut, 1);
    nextCyc(); snpValid = 0; #1;
    chk("R9", "state S after snoop", lineState, 1);
    chk("R9", "re-evaluated not done", cpuDone, 0);
    chk("R9", "re-evaluated cmd", busCmd, 2);
    busGrant = 1; snpValid = 1; snpCmd = 1; #1;
    chk("R9", "grant lost to snoop", busValid, 0);
    nextCyc(); snpValid = 0; #1;
    chk("R9", "I after snoop rdx", lineState, 0);
    chk("R9", "I write miss cmd", busCmd, 2);
    chk("R9", "valid now", busValid, 1);
    nextCyc(); quiet();
    chk("R4", "M after write miss", lineState, 3);
  endtask

  task automatic t_snoop_rdx_excl();
    cpuReq = 1; cpuWr = 0; cpuTag = TC; busGrant = 1; #1;  // M under TD: write-back first
    nextCyc(); #1;
    nextCyc(); quiet();
    chk("R2", "E on tag C", lineState, 2);
    snpValid = 1; snpCmd = 1; snpTag = TC; #1;
    chk("R7", "no flush on E", flushStb, 0);
    chk("R7", "no shared on rdx", sharedOut, 0);
    nextCyc(); quiet();
    chk("R7", "E invalidated", lineState, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #5 rstN = 1;
        #1;
        t_reset();
        t_read_miss_excl();
        t_silent_write();
        t_snoop_rd_mod();
        t_write_shared();
        t_snoop_rdx_mod();
        t_read_miss_shared();
        t_writeback();
        t_priority();
        t_snoop_rdx_excl();
        finished = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          nChk++; nFail++;
          $display("FAIL watchdog: actual running expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule